// File: doc/BRIEF.md
# Streaming Linear Complexity Engine

This block takes a binary stream one bit at a time. After each accepted bit it reports the linear complexity of the prefix received so far, which is the number of stages in the shortest linear feedback shift register whose first outputs reproduce that prefix. Alongside the complexity it gives the connection polynomial of one such shortest register and the current prefix length. The update is the Berlekamp-Massey iteration over GF(2), and each accepted bit costs exactly one clock cycle.

A producer offers bits through a valid/ready pair. A synchronous clear discards the current sequence and starts a new one. Once the parameterised maximum prefix length has been taken in, the block stops accepting bits until it is cleared. A consumer can read the complexity profile directly. It can also use the polynomial to rebuild a register that regenerates the stream.

The polynomial model has stages 0 to L−1. Stage 0 drives the output. On each step every stage hands its bit to the next lower stage, and the top stage takes the XOR of the stages that the polynomial selects. Coefficient i of the polynomial weights the bit produced i steps earlier.

Top module: `lc_engine`

## Requirements
- R1: After reset or clear, the prefix length and the complexity are 0, the polynomial is 1 (bit i of `conn_poly_o` is the coefficient of x^i), and `bit_ready_o` is high.
- R2: A bit is accepted at a rising edge where `bit_valid_i` and `bit_ready_o` are both high. Outputs update at that same edge and the prefix length grows by one. Without an accepted bit or a clear, all outputs hold.
- R3: After N_MAX accepted bits, `bit_ready_o` is low and further offered bits leave every output unchanged until a clear. The prefix length never exceeds N_MAX.
- R4: The complexity equals the length of the shortest register that generates the prefix. For example, the prefix 1,0,1 gives the profile 1,1,2 and an all-ones prefix gives 1 at every length.
- R5: The complexity stays 0 exactly while every received bit is 0.
- R6: A prefix made of k−1 zeros followed by a single 1 gives a complexity of k.
- R7: A stream from a k-stage register with a primitive connection polynomial and a nonzero seed settles at complexity k once 2k bits are in, and the reported polynomial then equals that primitive polynomial.
- R8: For a periodic stream of period T, the complexity never exceeds T.
- R9: The polynomial always has constant term 1 and degree at most the complexity L. For every j from L to n−1 it satisfies s_j = XOR over i=1..L of c_i·s_(j−i).
- R10: Within one sequence the complexity never decreases and never exceeds the prefix length.
- R11: When clear and an offered bit arrive in the same cycle, clear wins and the bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous restart of the sequence |
| bit_valid_i | input | 1 | Offered bit is valid |
| bit_i | input | 1 | Offered sequence bit |
| bit_ready_o | output | 1 | Engine can accept a bit |
| lin_cx_o | output | $clog2(N_MAX+1) | Linear complexity of current prefix |
| conn_poly_o | output | N_MAX+1 | Connection polynomial, bit i = coefficient of x^i |
| prefix_len_o | output | $clog2(N_MAX+1) | Number of bits accepted since clear |

## Verification
The bench builds the engine at the default N_MAX of 64. That is enough for a seven-stage primitive register to pass its 2k-bit settling point well before the prefix is full. The same run then fills the history completely, so the refusal at the full length and the recovery through clear are exercised too. Shorter four- and five-stage streams, periodic streams of period 3 and 5, and impulse and hand-worked prefixes cover the remaining profiles.

// File: rtl/lc_pkg.sv
package lc_pkg;

    // Kind of update applied to the engine state in one cycle
    typedef enum logic [1:0] {
        LC_HOLD   = 2'd0,  // no bit accepted
        LC_KEEP   = 2'd1,  // bit accepted, discrepancy zero
        LC_ADJUST = 2'd2,  // discrepancy one, length unchanged
        LC_GROW   = 2'd3   // discrepancy one, length increases
    } lc_step_e;

endpackage

// File: rtl/lc_history.sv
// Shift register of received bits; hist_o[0] holds the newest bit.
module lc_history #(
    parameter int N_MAX = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [N_MAX-1:0] hist_o
);
    logic [N_MAX-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (clear_i) begin
            hist_d = '0;
        end else if (shift_i) begin
            hist_d = {hist_q[N_MAX-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_o = hist_q;
endmodule

// File: rtl/lc_discrepancy.sv
// Discrepancy: incoming bit XOR parity of (c_i AND s_(n-i)) for i = 1..N_MAX.
module lc_discrepancy #(
    parameter int N_MAX = 64
) (
    input  logic [N_MAX:1]   taps_i,
    input  logic [N_MAX-1:0] hist_i,
    input  logic             bit_i,
    output logic             disc_o
);
    logic [N_MAX-1:0] prod;

    genvar gi;
    generate
        for (gi = 0; gi < N_MAX; gi++) begin : g_prod
            assign prod[gi] = taps_i[gi+1] & hist_i[gi];
        end
    endgenerate

    assign disc_o = bit_i ^ (^prod);
endmodule

// File: rtl/lc_poly_update.sv
// Correction term: c_i XOR (b_i shifted up by gap_i).
module lc_poly_update #(
    parameter int N_MAX = 64,
    parameter int GW    = 7
) (
    input  logic [N_MAX:0]  c_i,
    input  logic [N_MAX:0]  b_i,
    input  logic [GW-1:0]   gap_i,
    output logic [N_MAX:0]  c_o
);
    logic [N_MAX:0] b_shift;

    always_comb begin
        b_shift = b_i << gap_i;
        c_o     = c_i ^ b_shift;
    end
endmodule

// File: rtl/lc_step_ctrl.sv
// Chooses the update kind from handshake, discrepancy and the 2L <= n test.
module lc_step_ctrl
    import lc_pkg::*;
#(
    parameter int LW = 7
) (
    input  logic          accept_i,
    input  logic          disc_i,
    input  logic [LW-1:0] len_i,
    input  logic [LW-1:0] cnt_i,
    output lc_step_e      step_o
);
    logic [LW:0] twice_len;
    logic [LW:0] cnt_ext;

    always_comb begin
        twice_len = {len_i, 1'b0};
        cnt_ext   = {1'b0, cnt_i};
        if (!accept_i) begin
            step_o = LC_HOLD;
        end else if (!disc_i) begin
            step_o = LC_KEEP;
        end else if (twice_len <= cnt_ext) begin
            step_o = LC_GROW;
        end else begin
            step_o = LC_ADJUST;
        end
    end
endmodule

// File: rtl/lc_engine.sv
module lc_engine
    import lc_pkg::*;
#(
    parameter int N_MAX = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_i,
    input  logic                       bit_valid_i,
    input  logic                       bit_i,
    output logic                       bit_ready_o,
    output logic [$clog2(N_MAX+1)-1:0] lin_cx_o,
    output logic [N_MAX:0]             conn_poly_o,
    output logic [$clog2(N_MAX+1)-1:0] prefix_len_o
);
    localparam int LW = $clog2(N_MAX + 1);
    localparam int GW = $clog2(N_MAX + 2);
    localparam logic [LW-1:0] LAST_N = LW'(N_MAX);
    localparam logic [N_MAX:0] POLY_ONE = {{N_MAX{1'b0}}, 1'b1};

    typedef struct packed {
        logic [N_MAX:0] c;     // current connection polynomial
        logic [N_MAX:0] b;     // polynomial before the last length change
        logic [LW-1:0]  l;     // linear complexity
        logic [LW-1:0]  n;     // bits accepted
        logic [GW-1:0]  gap;   // n minus index of last length change
    } lc_state_t;

    lc_state_t st_d, st_q;

    logic             ready;
    logic             accept;
    logic             disc;
    logic [N_MAX-1:0] hist;
    logic [N_MAX:0]   c_fixed;
    lc_step_e         step;
    logic [LW:0]      l_grow;

    assign ready  = (st_q.n != LAST_N);
    assign accept = bit_valid_i & ready & ~clear_i;

    lc_history #(.N_MAX(N_MAX)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .shift_i (accept),
        .bit_i   (bit_i),
        .hist_o  (hist)
    );

    lc_discrepancy #(.N_MAX(N_MAX)) u_disc (
        .taps_i (st_q.c[N_MAX:1]),
        .hist_i (hist),
        .bit_i  (bit_i),
        .disc_o (disc)
    );

    lc_poly_update #(.N_MAX(N_MAX), .GW(GW)) u_upd (
        .c_i   (st_q.c),
        .b_i   (st_q.b),
        .gap_i (st_q.gap),
        .c_o   (c_fixed)
    );

    lc_step_ctrl #(.LW(LW)) u_ctrl (
        .accept_i (accept),
        .disc_i   (disc),
        .len_i    (st_q.l),
        .cnt_i    (st_q.n),
        .step_o   (step)
    );

    always_comb begin
        st_d   = st_q;
        l_grow = {1'b0, st_q.n} + {{LW{1'b0}}, 1'b1} - {1'b0, st_q.l};
        if (clear_i) begin
            st_d.c   = POLY_ONE;
            st_d.b   = POLY_ONE;
            st_d.l   = '0;
            st_d.n   = '0;
            st_d.gap = GW'(1);
        end else begin
            unique case (step)
                LC_HOLD: begin
                    st_d = st_q;
                end
                LC_KEEP: begin
                    st_d.n   = st_q.n + LW'(1);
                    st_d.gap = st_q.gap + GW'(1);
                end
                LC_ADJUST: begin
                    st_d.c   = c_fixed;
                    st_d.n   = st_q.n + LW'(1);
                    st_d.gap = st_q.gap + GW'(1);
                end
                LC_GROW: begin
                    st_d.c   = c_fixed;
                    st_d.b   = st_q.c;
                    st_d.l   = l_grow[LW-1:0];
                    st_d.n   = st_q.n + LW'(1);
                    st_d.gap = GW'(1);
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.c   <= POLY_ONE;
            st_q.b   <= POLY_ONE;
            st_q.l   <= '0;
            st_q.n   <= '0;
            st_q.gap <= GW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_ready_o  = ready;
    assign lin_cx_o     = st_q.l;
    assign conn_poly_o  = st_q.c;
    assign prefix_len_o = st_q.n;
endmodule

// File: rtl/lc_engine_chk.sv
module lc_engine_chk #(
    parameter int N_MAX = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       clear_i,
    input logic                       bit_valid_i,
    input logic                       bit_i,
    input logic                       bit_ready_o,
    input logic [$clog2(N_MAX+1)-1:0] lin_cx_o,
    input logic [N_MAX:0]             conn_poly_o,
    input logic [$clog2(N_MAX+1)-1:0] prefix_len_o
);
    localparam int LW = $clog2(N_MAX + 1);

    logic take;
    assign take = bit_valid_i & bit_ready_o & ~clear_i;

    assert_clear_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (prefix_len_o == '0) && (lin_cx_o == '0) && (conn_poly_o == (N_MAX+1)'(1)) && bit_ready_o);

    assert_len_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> prefix_len_o == $past(prefix_len_o) + LW'(1));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clear_i) |=> $stable(prefix_len_o) && $stable(lin_cx_o) && $stable(conn_poly_o));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prefix_len_o <= LW'(N_MAX));

    assert_poly_const_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conn_poly_o[0]);

    assert_cx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lin_cx_o <= prefix_len_o);

    assert_cx_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> lin_cx_o >= $past(lin_cx_o));

    assert_clear_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && bit_valid_i) |=> prefix_len_o == '0);

    logic unused_bit;
    assign unused_bit = bit_i;
endmodule

bind lc_engine lc_engine_chk #(.N_MAX(N_MAX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .bit_valid_i  (bit_valid_i),
    .bit_i        (bit_i),
    .bit_ready_o  (bit_ready_o),
    .lin_cx_o     (lin_cx_o),
    .conn_poly_o  (conn_poly_o),
    .prefix_len_o (prefix_len_o)
);

// File: tb/tb_lc_engine.sv
`timescale 1ns/1ps
module tb_lc_engine;
    localparam int N  = 64;
    localparam int LW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_i = 1'b0;
    logic          bit_valid_i = 1'b0;
    logic          bit_i = 1'b0;
    logic          bit_ready_o;
    logic [LW-1:0] lin_cx_o;
    logic [N:0]    conn_poly_o;
    logic [LW-1:0] prefix_len_o;

    int n_chk = 0;
    int n_bad = 0;
    int cnt = 0;
    bit seq [N];

    always #2 clk = ~clk;

    lc_engine #(.N_MAX(N)) dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .bit_valid_i(bit_valid_i), .bit_i(bit_i), .bit_ready_o(bit_ready_o),
        .lin_cx_o(lin_cx_o), .conn_poly_o(conn_poly_o), .prefix_len_o(prefix_len_o)
    );

    task automatic check_eq(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit regen_ok(input logic [N:0] p, input int l, input int n);
        for (int i = l + 1; i <= N; i++) if (p[i]) return 1'b0;
        if (!p[0]) return 1'b0;
        for (int j = l; j < n; j++) begin
            bit acc = seq[j];
            for (int i = 1; i <= l; i++) acc ^= p[i] & seq[j-i];
            if (acc) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic do_clear();
        @(negedge clk) clear_i = 1'b1;
        @(negedge clk) clear_i = 1'b0;
        cnt = 0;
    endtask

    task automatic push(input bit b);
        @(negedge clk) begin bit_valid_i = 1'b1; bit_i = b; end
        @(negedge clk) bit_valid_i = 1'b0;
        seq[cnt] = b;
        cnt++;
    endtask

    task automatic t_reset();
        check_eq("R1 len", prefix_len_o, 0);
        check_eq("R1 cx", lin_cx_o, 0);
        check_eq("R1 poly", conn_poly_o, 1);
        check_eq("R1 ready", bit_ready_o, 1);
    endtask

    task automatic t_hold();
        do_clear();
        push(1'b1);
        push(1'b1);
        repeat (5) @(negedge clk);
        check_eq("R2 len held", prefix_len_o, 2);
        check_eq("R2 cx held", lin_cx_o, 1);
        check_eq("R4 all-ones poly", conn_poly_o, 3);
    endtask

    task automatic t_zeros();
        do_clear();
        for (int k = 1; k <= 10; k++) begin
            push(1'b0);
            check_eq("R5 zero prefix cx", lin_cx_o, 0);
            check_eq("R2 len step", prefix_len_o, k);
        end
        push(1'b1);
        check_eq("R6 impulse 11 cx", lin_cx_o, 11);
        check_eq("R9 impulse regen", regen_ok(conn_poly_o, lin_cx_o, cnt), 1);
    endtask

    task automatic t_impulse(input int k);
        do_clear();
        for (int i = 0; i < k - 1; i++) push(1'b0);
        push(1'b1);
        check_eq("R6 impulse cx", lin_cx_o, k);
    endtask

    task automatic t_profile();
        do_clear();
        push(1'b1); check_eq("R4 prof n1", lin_cx_o, 1);
        push(1'b0); check_eq("R4 prof n2", lin_cx_o, 1);
        push(1'b1); check_eq("R4 prof n3", lin_cx_o, 2);
        check_eq("R9 prof poly", conn_poly_o, 5);
        do_clear();
        for (int i = 1; i <= 6; i++) begin
            push(1'b1);
            check_eq("R4 ones cx", lin_cx_o, 1);
        end
    endtask

    task automatic t_prim(input int deg, input logic [N:0] p, input int len);
        int prev = 0;
        do_clear();
        for (int j = 0; j < len; j++) begin
            bit b;
            if (j < deg) b = (j == 0);
            else begin
                b = 1'b0;
                for (int i = 1; i <= deg; i++) b ^= p[i] & seq[j-i];
            end
            push(b);
            check_eq("R9 regen", regen_ok(conn_poly_o, lin_cx_o, cnt), 1);
            check_eq("R10 monotone", (lin_cx_o >= prev) && (lin_cx_o <= cnt), 1);
            prev = lin_cx_o;
        end
        check_eq("R7 settle cx", lin_cx_o, deg);
        check_eq("R7 poly", conn_poly_o, p);
    endtask

    task automatic t_periodic(input int per, input logic [7:0] pat, input int len);
        do_clear();
        for (int j = 0; j < len; j++) begin
            push(pat[j % per]);
            check_eq("R8 cx within period", lin_cx_o <= per, 1);
        end
        check_eq("R9 periodic regen", regen_ok(conn_poly_o, lin_cx_o, cnt), 1);
    endtask

    task automatic t_overflow();
        logic [N:0] p_save;
        logic [LW-1:0] l_save;
        t_prim(7, (N+1)'('hC1), N);
        check_eq("R3 ready low", bit_ready_o, 0);
        check_eq("R3 len full", prefix_len_o, N);
        p_save = conn_poly_o;
        l_save = lin_cx_o;
        @(negedge clk) begin bit_valid_i = 1'b1; bit_i = ~seq[N-1]; end
        repeat (3) @(negedge clk);
        bit_valid_i = 1'b0;
        check_eq("R3 len unchanged", prefix_len_o, N);
        check_eq("R3 cx unchanged", lin_cx_o, l_save);
        check_eq("R3 poly unchanged", conn_poly_o == p_save, 1);
        do_clear();
        check_eq("R1 clear ready", bit_ready_o, 1);
        check_eq("R1 clear len", prefix_len_o, 0);
        check_eq("R1 clear poly", conn_poly_o, 1);
    endtask

    task automatic t_clear_prio();
        do_clear();
        push(1'b0);
        push(1'b0);
        @(negedge clk) begin clear_i = 1'b1; bit_valid_i = 1'b1; bit_i = 1'b1; end
        @(negedge clk) begin clear_i = 1'b0; bit_valid_i = 1'b0; end
        cnt = 0;
        check_eq("R11 len", prefix_len_o, 0);
        check_eq("R11 cx", lin_cx_o, 0);
        push(1'b1);
        check_eq("R11 after len", prefix_len_o, 1);
        check_eq("R11 after cx", lin_cx_o, 1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_zeros();
        t_impulse(1);
        t_impulse(3);
        t_impulse(6);
        t_profile();
        t_prim(4, (N+1)'('h19), 20);
        t_prim(5, (N+1)'('h29), 30);
        t_periodic(3, 8'b011, 30);
        t_periodic(5, 8'b10000, 40);
        t_overflow();
        t_clear_prio();
        finish_run();
    end
endmodule